// File: doc/BRIEF.md
# Calendar Time-of-Day Register Block

This block keeps wall-clock time and a calendar date for a chip. A one-cycle `tick` pulse marks each elapsed second. On each tick the seconds advance and, as each field wraps, the carry passes on to minutes, hours, day of month, month and year. The day count depends on the month and on a leap flag stored with the date. The year is an offset from 1970 in six bits, so the count runs from 1970 to 2033.

Software uses a small register bus. A request channel with valid/ready carries an address, a write flag and write data. Reads return one word on a response channel that also uses valid/ready. There is one response slot. A new request is taken only when that slot is empty or is being drained in the same cycle, so a stalled `rsp_ready` holds back the request channel. Writes to the time word or the date word do not land at once. Each one is parked in a holding register and raises its own busy bit in the control word. The new value loads after a fixed delay of `COMMIT_DELAY` cycles, and the busy bit drops on that same edge. Software polls the busy bits before it writes again. Because the counters keep running, software that wants a consistent time and date reads both words twice and repeats until two passes agree.

Top module: `caltime_regs`

## Requirements
- R1: The time word at address 1 holds seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. Every other bit reads as zero, whatever was written to it.
- R2: The date word at address 2 holds the day of month in bits 4:0, the month (1 to 12) in bits 11:8, the year offset from 1970 in bits 21:16 and the leap flag in bit 22. Every other bit reads as zero.
- R3: The control word at address 0 is read-only. Bit 8 is set on the edge that accepts a time-word write, and bit 7 on the edge that accepts a date-word write. Each stays set for exactly `COMMIT_DELAY` cycles and clears on the edge where the value loads. Bit 9 and every other bit read as zero.
- R4: A write to a word whose busy bit is set has no effect. A write to the control word, or to any address above 2, has no effect.
- R5: Until the commit edge, a read returns the running value, not the pending value. From the commit edge onward, a read returns the written value.
- R6: Each tick advances the seconds. Seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, and hours wrap from 23 to 0 and carry into the date.
- R7: On a carry into the date, the day wraps to 1 after the last day of the month and the month advances. The last day is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11. For month 2 it is 29 when the leap flag is 1 and 28 when it is 0.
- R8: Month 12 wraps to 1 and the year offset increments, wrapping from 63 to 0. The leap flag is then set to 1 exactly when the new year offset modulo 4 equals 2, which is when 1970 plus the offset is divisible by 4.
- R9: On a time-word commit edge, the loaded value replaces the tick's advance for that edge, and no carry reaches the date. On a date-word commit edge, the loaded value replaces any carry from the time word.
- R10: `req_ready` is high when `rsp_valid` is low or `rsp_ready` is high. A read accepted on an edge presents its data with `rsp_valid` on the next cycle. That data and `rsp_valid` hold steady while `rsp_ready` is low. Writes produce no response.
- R11: After reset the time is 00:00:00, the date is day 1, month 1, year offset 0 with the leap flag at 0, and both busy bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse for each elapsed second |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address: 0 control, 1 time, 2 date |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_data | output | 32 | Read data |

## Verification
The hardest cases to reach are a tick that falls exactly on a commit edge, and a midnight carry that lands on the same edge as a date commit. Both depend on a write being accepted exactly `COMMIT_DELAY` cycles before a chosen tick. The bench reaches them in two ways. It holds `tick` high on every cycle while it issues a write, so the commit edge meets a tick. It also loads 23:59:59 first, then writes the date and fires one tick timed to the date's commit edge. A cycle-by-cycle behavioural model in the bench tracks every edge. Back-pressure is covered by holding `rsp_ready` low across queued reads.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

  // Field order inside each packed word is fixed by software decoding.
  typedef struct packed {
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } tod_t;

  typedef struct packed {
    logic       leap;
    logic [5:0] year;
    logic [3:0] month;
    logic [4:0] day;
  } cal_t;

  localparam int TOD_W = $bits(tod_t);
  localparam int CAL_W = $bits(cal_t);

  localparam int BUSY_CAL_BIT = 7;
  localparam int BUSY_TOD_BIT = 8;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_TOD  = 2'd1,
    REG_CAL  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  function automatic logic [31:0] tod_to_word(input tod_t t);
    return {11'b0, t.hour, 2'b0, t.min, 2'b0, t.sec};
  endfunction

  function automatic logic [31:0] cal_to_word(input cal_t c);
    return {9'b0, c.leap, c.year, 4'b0, c.month, 3'b0, c.day};
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
    case (m)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

  // 1970 leaves remainder 2 modulo 4.
  function automatic logic leap_of(input logic [5:0] y);
    return (y[1:0] == 2'd2);
  endfunction

endpackage

// File: rtl/caltime_commit.sv
module caltime_commit #(
  parameter int W     = 17,
  parameter int DELAY = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] din,
  output logic         busy,
  output logic         commit,
  output logic [W-1:0] hold
);
  localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;

  logic [CW-1:0] cnt;

  assign commit = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      hold <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(DELAY - 1);
      hold <= din;
    end
  end
endmodule

// File: rtl/caltime_clock.sv
module caltime_clock
  import caltime_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tod_load,
  input  tod_t tod_new,
  input  logic cal_load,
  input  cal_t cal_new,
  output tod_t tod,
  output cal_t cal,
  output logic day_carry
);
  tod_t tod_inc;
  cal_t cal_inc;
  logic wrap_day;

  always_comb begin
    tod_inc  = tod;
    wrap_day = 1'b0;
    if (tod.sec >= 6'd59) begin
      tod_inc.sec = '0;
      if (tod.min >= 6'd59) begin
        tod_inc.min = '0;
        if (tod.hour >= 5'd23) begin
          tod_inc.hour = '0;
          wrap_day     = 1'b1;
        end else begin
          tod_inc.hour = tod.hour + 1'b1;
        end
      end else begin
        tod_inc.min = tod.min + 1'b1;
      end
    end else begin
      tod_inc.sec = tod.sec + 1'b1;
    end
  end

  assign day_carry = tick && !tod_load && wrap_day;

  always_comb begin
    cal_inc = cal;
    if (cal.day >= month_len(cal.month, cal.leap)) begin
      cal_inc.day = 5'd1;
      if (cal.month >= 4'd12) begin
        cal_inc.month = 4'd1;
        cal_inc.year  = cal.year + 1'b1;
        cal_inc.leap  = leap_of(cal.year + 1'b1);
      end else begin
        cal_inc.month = cal.month + 1'b1;
      end
    end else begin
      cal_inc.day = cal.day + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tod <= '0;
      cal <= '{leap: 1'b0, year: 6'd0, month: 4'd1, day: 5'd1};
    end else begin
      if (tod_load)  tod <= tod_new;
      else if (tick) tod <= tod_inc;
      if (cal_load)       cal <= cal_new;
      else if (day_carry) cal <= cal_inc;
    end
  end
endmodule

// File: rtl/caltime_bus.sv
module caltime_bus
  import caltime_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  input  tod_t              tod,
  input  cal_t              cal,
  input  logic              tod_busy,
  input  logic              cal_busy,
  output logic              tod_start,
  output tod_t              tod_din,
  output logic              cal_start,
  output cal_t              cal_din
);
  reg_sel_e    sel;
  logic        accept;
  logic [31:0] rd_word;
  logic        unused_wbits;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    if (req_addr > ADDR_W'(2)) sel = REG_NONE;
    else                       sel = reg_sel_e'(req_addr[1:0]);
  end

  assign tod_din   = '{hour: req_wdata[20:16], min: req_wdata[13:8], sec: req_wdata[5:0]};
  assign cal_din   = '{leap: req_wdata[22], year: req_wdata[21:16],
                       month: req_wdata[11:8], day: req_wdata[4:0]};
  assign tod_start = accept && req_write && (sel == REG_TOD) && !tod_busy;
  assign cal_start = accept && req_write && (sel == REG_CAL) && !cal_busy;

  assign unused_wbits = ^{req_wdata[31:23], req_wdata[15:14], req_wdata[7:6]};

  always_comb begin
    rd_word = '0;
    case (sel)
      REG_CTRL: begin
        rd_word[BUSY_TOD_BIT] = tod_busy;
        rd_word[BUSY_CAL_BIT] = cal_busy;
      end
      REG_TOD: rd_word = tod_to_word(tod);
      REG_CAL: rd_word = cal_to_word(cal);
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/caltime_regs.sv
module caltime_regs
  import caltime_pkg::*;
#(
  parameter int COMMIT_DELAY = 3,
  parameter int ADDR_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data
);
  tod_t tod_din, tod_hold, cur_tod;
  cal_t cal_din, cal_hold, cur_cal;
  logic tod_start, tod_busy, tod_commit;
  logic cal_start, cal_busy, cal_commit;
  logic day_carry;

  caltime_bus #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .tod(cur_tod), .cal(cur_cal), .tod_busy(tod_busy), .cal_busy(cal_busy),
    .tod_start(tod_start), .tod_din(tod_din),
    .cal_start(cal_start), .cal_din(cal_din)
  );

  caltime_commit #(.W(TOD_W), .DELAY(COMMIT_DELAY)) u_tod_commit (
    .clk(clk), .rst_n(rst_n), .start(tod_start), .din(tod_din),
    .busy(tod_busy), .commit(tod_commit), .hold(tod_hold)
  );

  caltime_commit #(.W(CAL_W), .DELAY(COMMIT_DELAY)) u_cal_commit (
    .clk(clk), .rst_n(rst_n), .start(cal_start), .din(cal_din),
    .busy(cal_busy), .commit(cal_commit), .hold(cal_hold)
  );

  caltime_clock u_clock (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .tod_load(tod_commit), .tod_new(tod_hold),
    .cal_load(cal_commit), .cal_new(cal_hold),
    .tod(cur_tod), .cal(cur_cal), .day_carry(day_carry)
  );
endmodule

// File: rtl/caltime_regs_chk.sv
module caltime_regs_chk
  import caltime_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic        tod_busy,
  input logic        tod_commit,
  input tod_t        tod_hold,
  input tod_t        cur_tod,
  input cal_t        cur_cal,
  input logic        cal_commit,
  input logic        day_carry
);
  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tod_busy && !tod_commit |=> tod_busy);

  assert_busy_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tod_commit |=> !tod_busy);

  assert_hold_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tod_busy |=> $stable(tod_hold));

  assert_commit_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tod_commit |=> cur_tod == $past(tod_hold));

  assert_sec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !tod_commit && cur_tod.sec == 6'd59 |=> cur_tod.sec == 6'd0);

  assert_year_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry && !cal_commit && cur_cal.month == 4'd12 && cur_cal.day == 5'd31
    |=> cur_cal.month == 4'd1 && cur_cal.day == 5'd1);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
endmodule

bind caltime_regs caltime_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .tod_busy(tod_busy), .tod_commit(tod_commit), .tod_hold(tod_hold),
  .cur_tod(cur_tod), .cur_cal(cur_cal), .cal_commit(cal_commit),
  .day_carry(day_carry)
);

// File: tb/caltime_regs_bench.sv
module caltime_regs_bench;
  localparam int D = 3;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic        req_write = 0;
  logic [3:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic [31:0] rsp_data;

  always #2 clk = ~clk;

  caltime_regs #(.COMMIT_DELAY(D), .ADDR_W(4)) u_caltime_regs (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R11";

  // Behavioural reference state.
  int m_sec = 0, m_min = 0, m_hr = 0;
  int m_day = 1, m_mon = 1, m_yr = 0, m_leap = 0;
  int bt = 0, bd = 0, ct = 0, cd = 0;
  logic [31:0] pend_t = 0, pend_d = 0;
  int m_rv = 0;
  logic [31:0] m_rd = 0;
  int last_acc = 0;

  function automatic int days_in(int mo, int lp);
    if (mo == 2) return lp ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] m_read(int a);
    if (a == 0) return (32'(bt) << 8) | (32'(bd) << 7);
    if (a == 1) return (32'(m_hr) << 16) | (32'(m_min) << 8) | 32'(m_sec);
    if (a == 2) return (32'(m_leap) << 22) | (32'(m_yr) << 16) | (32'(m_mon) << 8) | 32'(m_day);
    return 0;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    int ready, acc, ctk, cdk, carry;
    logic [31:0] rd;
    @(negedge clk);
    chk("rsp_valid", 32'(rsp_valid), 32'(m_rv));
    if (m_rv != 0) chk("rsp_data", rsp_data, m_rd);
    ready = (m_rv == 0 || rsp_ready) ? 1 : 0;
    chk("req_ready (R10)", 32'(req_ready), 32'(ready));
    acc = (req_valid && ready != 0) ? 1 : 0;
    last_acc = acc;
    ctk = (bt != 0 && ct == 0) ? 1 : 0;
    cdk = (bd != 0 && cd == 0) ? 1 : 0;
    rd = m_read(int'(req_addr));
    carry = 0;
    if (ctk != 0) begin
      m_sec = int'(pend_t[5:0]); m_min = int'(pend_t[13:8]); m_hr = int'(pend_t[20:16]);
    end else if (tick) begin
      m_sec++;
      if (m_sec == 60) begin
        m_sec = 0; m_min++;
        if (m_min == 60) begin
          m_min = 0; m_hr++;
          if (m_hr == 24) begin m_hr = 0; carry = 1; end
        end
      end
    end
    if (cdk != 0) begin
      m_day = int'(pend_d[4:0]); m_mon = int'(pend_d[11:8]);
      m_yr = int'(pend_d[21:16]); m_leap = int'(pend_d[22]);
    end else if (carry != 0) begin
      if (m_day >= days_in(m_mon, m_leap)) begin
        m_day = 1;
        if (m_mon >= 12) begin
          m_mon = 1; m_yr = (m_yr + 1) % 64;
          m_leap = (m_yr % 4 == 2) ? 1 : 0;
        end else m_mon++;
      end else m_day++;
    end
    if (bt != 0) begin
      if (ct == 0) bt = 0; else ct--;
    end else if (acc != 0 && req_write && req_addr == 1) begin
      bt = 1; ct = D - 1; pend_t = req_wdata;
    end
    if (bd != 0) begin
      if (cd == 0) bd = 0; else cd--;
    end else if (acc != 0 && req_write && req_addr == 2) begin
      bd = 1; cd = D - 1; pend_d = req_wdata;
    end
    if (acc != 0 && !req_write) begin m_rv = 1; m_rd = rd; end
    else if (rsp_ready) m_rv = 0;
    @(posedge clk); #1;
  endtask

  task automatic idle(int n, logic tk);
    req_valid = 0; tick = tk;
    for (int i = 0; i < n; i++) step();
    tick = 0;
  endtask

  task automatic issue(logic wr, int a, logic [31:0] d);
    req_valid = 1; req_write = wr; req_addr = 4'(a); req_wdata = d;
    step();
    while (last_acc == 0) step();
    req_valid = 0;
  endtask

  task automatic rd(int a);
    issue(0, a, 0);
    step();
  endtask

  task automatic load(logic [31:0] t, logic [31:0] dt);
    issue(1, 1, t);
    issue(1, 2, dt);
    idle(D + 1, 0);
  endtask

  function automatic logic [31:0] tw(int h, int m, int s);
    return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  function automatic logic [31:0] dw(int lp, int y, int mo, int d);
    return (32'(lp) << 22) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
  endfunction

  task automatic midnight(logic [31:0] dt);
    load(tw(23, 59, 59), dt);
    idle(1, 1);
    rd(2); rd(1);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;

    tag = "R11";
    rd(0); rd(1); rd(2);

    tag = "R1 R3 R5";
    issue(1, 1, 32'hFFC0C0C0 | tw(12, 34, 56));
    rd(0); rd(1); rd(1); rd(0); rd(1);

    tag = "R4";
    issue(1, 1, tw(1, 2, 3));
    issue(1, 1, tw(9, 9, 9));
    idle(D + 1, 0);
    rd(1);
    issue(1, 0, 32'hFFFFFFFF);
    rd(0);
    issue(1, 7, 32'h12345678);
    rd(7); rd(1); rd(2);

    tag = "R2 R3";
    issue(1, 2, 32'hFF80F0E0 | dw(1, 2, 2, 29));
    rd(0); rd(2); idle(D, 0); rd(2); rd(0);

    tag = "R6";
    load(tw(0, 59, 58), dw(0, 3, 3, 10));
    idle(3, 1); rd(1);
    load(tw(13, 59, 59), dw(0, 3, 3, 10));
    idle(1, 1); rd(1); rd(2);

    tag = "R7";
    midnight(dw(1, 2, 2, 28));
    midnight(dw(1, 2, 2, 29));
    midnight(dw(0, 3, 2, 28));
    midnight(dw(0, 3, 4, 30));
    midnight(dw(0, 3, 1, 31));
    midnight(dw(0, 3, 1, 30));
    midnight(dw(0, 3, 11, 30));

    tag = "R8";
    midnight(dw(0, 1, 12, 31));
    midnight(dw(1, 2, 12, 31));
    midnight(dw(0, 63, 12, 31));

    tag = "R9";
    tick = 1;
    req_valid = 1; req_write = 1; req_addr = 1; req_wdata = tw(5, 5, 5);
    step();
    req_valid = 0;
    for (int i = 0; i < D + 2; i++) step();
    tick = 0;
    rd(1);
    load(tw(23, 59, 50), dw(0, 3, 6, 30));
    issue(1, 2, dw(0, 4, 8, 15));
    idle(D - 2, 0);
    load(tw(23, 59, 59), dw(0, 3, 6, 30));
    issue(1, 2, dw(0, 4, 8, 15));
    req_valid = 0;
    for (int i = 0; i < D - 1; i++) step();
    idle(1, 1);
    rd(2); rd(1);

    tag = "R10";
    rsp_ready = 0;
    issue(0, 1, 0);
    req_valid = 1; req_write = 0; req_addr = 2;
    step(); step(); step();
    rsp_ready = 1;
    step();
    while (last_acc == 0) step();
    req_valid = 0;
    step(); step();
    rsp_ready = 0;
    issue(1, 2, 0);
    rsp_ready = 1;
    step(); step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule